// File: doc/BRIEF.md
# Command Slot Activation Tracker

This block keeps the book of outstanding commands for a single storage port. Up to 31 command slots exist. Software arms a slot by writing a 64-bit descriptor address into that slot's eight-byte activation window: the low word first, which is only staged, then the upper word, which arms the slot and hands the full address to the execution side as a one-cycle issue pulse.

An execution engine, outside this block, reports back through two plain strobes. A completion names a slot and retires it. A failure raises a sticky attention flag in the top bit of the slot status word and records a numeric cause code. The failing slot stays marked busy. Both strobes are echoed as one-cycle event pulses for the interrupt logic. A port-initialize write wipes the busy bits, attention, the cause code and the misuse flag. Arming a slot that is still busy is refused and latches a sticky misuse flag.

Top module: `csat_tracker`

## Requirements
- R1: After reset every slot is idle, status (0x100), cause code (0x104) and misuse flag (0x108) read 0, and issue_valid, evt_complete and evt_error are low.
- R2: A write to a slot's low word (byte offset slot*8) stores the value but neither arms the slot nor pulses issue_valid.
- R3: A write to a slot's upper word (byte offset slot*8+4) on an idle slot sets status bit `slot` at that clock edge; in the next cycle only, issue_valid is high with issue_slot = slot and issue_addr = {upper, low}.
- R4: Reading offset slot*8 or slot*8+4 returns the stored low or upper descriptor word.
- R5: done_valid for a busy slot clears its status bit at that edge and pulses evt_complete for the next cycle; done_valid for an idle slot changes nothing and gives no pulse.
- R6: fail_valid sets status bit 31 (attention), leaves the busy bits as they are, captures fail_code into the cause register when attention was clear, and pulses evt_error for the next cycle.
- R7: While attention is set, further failures do not change the cause code, and attention stays set.
- R8: A write of 1 in bit 0 to offset 0x10C clears all busy bits, attention, the cause code and the misuse flag; a write there with bit 0 clear does nothing.
- R9: An upper-word write to a busy slot leaves the slot and its descriptor unchanged, gives no issue pulse, and sets the sticky misuse flag (bit 0 at 0x108); a low-word write to a busy slot is discarded.
- R10: Writes to offsets at or above slot count*8 outside the register set, and writes with address bits 1:0 non-zero, have no effect; reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Byte address of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 12 | Byte address of the read |
| reg_rd_data | output | 32 | Read data, combinational from reg_rd_addr |
| issue_valid | output | 1 | One-cycle pulse for an armed slot |
| issue_slot | output | 5 | Slot number of the issue |
| issue_addr | output | 64 | Descriptor address of the issue |
| done_valid | input | 1 | Completion strobe from the execution engine |
| done_slot | input | 5 | Slot that completed |
| fail_valid | input | 1 | Failure strobe from the execution engine |
| fail_code | input | 8 | Cause code of the failure |
| evt_complete | output | 1 | Completion event pulse |
| evt_error | output | 1 | Error event pulse |

## Verification
A table of register writes and reads walks the arming path with staged-only low words, armed slots at both ends of the slot range, re-arming of a busy slot, low writes to a busy slot, out-of-range and misaligned writes and both values of the initialize bit; each read tells apart a design that arms too early, overwrites a live descriptor or decodes past the last slot. Directed sequences then drive completions for a busy and an idle slot, a failure with a first and a second cause code, and initialization with attention set, separating a cause register that keeps the first code from one that keeps the last and an event that fires for a stale completion from one that does not.

// File: rtl/csat_pkg.sv
package csat_pkg;

   localparam int unsigned DATA_W     = 32;
   localparam int unsigned STATUS_OFF = 32'h100;
   localparam int unsigned CAUSE_OFF  = 32'h104;
   localparam int unsigned MISUSE_OFF = 32'h108;
   localparam int unsigned INIT_OFF   = 32'h10C;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_ACT_LO,
      ACC_ACT_HI,
      ACC_STATUS,
      ACC_CAUSE,
      ACC_MISUSE,
      ACC_INIT
   } acc_e;

endpackage

// File: rtl/csat_decode.sv
module csat_decode
   import csat_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int ADDR_W    = 12,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_e              kind,
   output logic [SLOT_W-1:0] slot
);

   localparam logic [ADDR_W-1:0] ACT_END  = ADDR_W'(NUM_SLOTS * 8);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_OFF);
   localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(CAUSE_OFF);
   localparam logic [ADDR_W-1:0] A_MISUSE = ADDR_W'(MISUSE_OFF);
   localparam logic [ADDR_W-1:0] A_INIT   = ADDR_W'(INIT_OFF);

   assign slot = addr[SLOT_W+2:3];

   always_comb begin
      kind = ACC_NONE;
      if (addr[1:0] == 2'b00) begin
         if (addr < ACT_END)         kind = addr[2] ? ACC_ACT_HI : ACC_ACT_LO;
         else if (addr == A_STATUS)  kind = ACC_STATUS;
         else if (addr == A_CAUSE)   kind = ACC_CAUSE;
         else if (addr == A_MISUSE)  kind = ACC_MISUSE;
         else if (addr == A_INIT)    kind = ACC_INIT;
      end
   end

endmodule

// File: rtl/csat_slot_bank.sv
module csat_slot_bank #(
   parameter int NUM_SLOTS = 31,
   parameter int WORD_W    = 32,
   localparam int SLOT_W   = $clog2(NUM_SLOTS),
   localparam int PAD_N    = 2 ** SLOT_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lo_we,
   input  logic                 hi_we,
   input  logic [SLOT_W-1:0]    wslot,
   input  logic [WORD_W-1:0]    wdata,
   input  logic                 done_valid,
   input  logic [SLOT_W-1:0]    done_slot,
   input  logic                 init_clr,
   input  logic [SLOT_W-1:0]    rslot,
   output logic [NUM_SLOTS-1:0] active,
   output logic [WORD_W-1:0]    rd_lo,
   output logic [WORD_W-1:0]    rd_hi,
   output logic [WORD_W-1:0]    wr_lo,
   output logic                 act_ok,
   output logic                 act_rej,
   output logic                 done_hit
);

   logic [WORD_W-1:0] lo_q [NUM_SLOTS];
   logic [WORD_W-1:0] hi_q [NUM_SLOTS];
   logic [PAD_N-1:0]  act_pad;

   always_comb begin
      act_pad = '0;
      act_pad[NUM_SLOTS-1:0] = active;
   end

   assign act_ok   = hi_we & ~act_pad[wslot] & ~init_clr;
   assign act_rej  = hi_we &  act_pad[wslot] & ~init_clr;
   assign done_hit = done_valid & act_pad[done_slot];

   always_comb begin
      rd_lo = '0;
      rd_hi = '0;
      wr_lo = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         if (rslot == SLOT_W'(i)) begin
            rd_lo = lo_q[i];
            rd_hi = hi_q[i];
         end
         if (wslot == SLOT_W'(i)) wr_lo = lo_q[i];
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      logic sel_w, sel_d;
      assign sel_w = (wslot == SLOT_W'(g));
      assign sel_d = done_valid & (done_slot == SLOT_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            active[g] <= 1'b0;
         end else if (init_clr) begin
            active[g] <= 1'b0;
         end else begin
            if (sel_d)           active[g] <= 1'b0;
            if (act_ok && sel_w) active[g] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q[g] <= '0;
            hi_q[g] <= '0;
         end else begin
            if (lo_we && sel_w && !active[g]) lo_q[g] <= wdata;
            if (act_ok && sel_w)              hi_q[g] <= wdata;
         end
      end

      // R5: a completion retires its slot unless re-armed in the same cycle
      a_r5_done_retires: assert property (@(posedge clk) disable iff (!rst_n)
         sel_d && !(act_ok && sel_w) |=> !active[g]);

      // R9: a busy slot keeps its upper descriptor word
      a_r9_busy_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
         active[g] && !init_clr && !sel_d |=> $stable(hi_q[g]));
   end

endmodule

// File: rtl/csat_err_capture.sv
module csat_err_capture #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fail_valid,
   input  logic [CODE_W-1:0] fail_code,
   input  logic              act_rej,
   input  logic              init_clr,
   output logic              attn,
   output logic [CODE_W-1:0] cause,
   output logic              misuse
);

   always_ff @(posedge clk) begin
      if (!rst_n || init_clr) begin
         attn   <= 1'b0;
         cause  <= '0;
         misuse <= 1'b0;
      end else begin
         if (fail_valid)          attn   <= 1'b1;
         if (fail_valid && !attn) cause  <= fail_code;
         if (act_rej)             misuse <= 1'b1;
      end
   end

   // R6: a failure without a concurrent initialize leaves attention set
   a_r6_fail_sets_attn: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid && !init_clr |=> attn);

   // R7: the captured cause holds while attention is up
   a_r7_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      attn && !init_clr |=> attn && $stable(cause));

   // R9: the misuse flag is sticky
   a_r9_misuse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      misuse && !init_clr |=> misuse);

endmodule

// File: rtl/csat_tracker.sv
module csat_tracker
   import csat_pkg::*;
#(
   parameter int NUM_SLOTS = 31,
   parameter int ADDR_W    = 12,
   parameter int CODE_W    = 8,
   localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_wr_addr,
   input  logic [31:0]       reg_wr_data,
   input  logic [ADDR_W-1:0] reg_rd_addr,
   output logic [31:0]       reg_rd_data,
   output logic              issue_valid,
   output logic [SLOT_W-1:0] issue_slot,
   output logic [63:0]       issue_addr,
   input  logic              done_valid,
   input  logic [SLOT_W-1:0] done_slot,
   input  logic              fail_valid,
   input  logic [CODE_W-1:0] fail_code,
   output logic              evt_complete,
   output logic              evt_error
);

   if (NUM_SLOTS < 2 || NUM_SLOTS > 31) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 2..31 so bit 31 stays free for attention");
   end
   if (CODE_W < 1 || CODE_W > 32) begin : g_bad_code
      $error("CODE_W must lie in 1..32");
   end
   if (NUM_SLOTS * 8 > int'(STATUS_OFF) || ADDR_W < 9 || ADDR_W > 31) begin : g_bad_addr
      $error("ADDR_W too small or activation windows overlap the register set");
   end

   acc_e              wkind, rkind;
   logic [SLOT_W-1:0] wslot, rslot;
   logic              lo_we, hi_we, init_clr;
   logic [NUM_SLOTS-1:0] active;
   logic [31:0]       rd_lo, rd_hi, wr_lo;
   logic              act_ok, act_rej, done_hit;
   logic              attn, misuse;
   logic [CODE_W-1:0] cause;
   logic [31:0]       status_w, cause_w;

   csat_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_wdec (
      .addr(reg_wr_addr), .kind(wkind), .slot(wslot));

   csat_decode #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_rdec (
      .addr(reg_rd_addr), .kind(rkind), .slot(rslot));

   assign lo_we    = reg_wr_en && (wkind == ACC_ACT_LO);
   assign hi_we    = reg_wr_en && (wkind == ACC_ACT_HI);
   assign init_clr = reg_wr_en && (wkind == ACC_INIT) && reg_wr_data[0];

   csat_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .WORD_W(32)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .lo_we      (lo_we),
      .hi_we      (hi_we),
      .wslot      (wslot),
      .wdata      (reg_wr_data),
      .done_valid (done_valid),
      .done_slot  (done_slot),
      .init_clr   (init_clr),
      .rslot      (rslot),
      .active     (active),
      .rd_lo      (rd_lo),
      .rd_hi      (rd_hi),
      .wr_lo      (wr_lo),
      .act_ok     (act_ok),
      .act_rej    (act_rej),
      .done_hit   (done_hit)
   );

   csat_err_capture #(.CODE_W(CODE_W)) u_err (
      .clk        (clk),
      .rst_n      (rst_n),
      .fail_valid (fail_valid),
      .fail_code  (fail_code),
      .act_rej    (act_rej),
      .init_clr   (init_clr),
      .attn       (attn),
      .cause      (cause),
      .misuse     (misuse)
   );

   always_comb begin
      status_w = '0;
      status_w[NUM_SLOTS-1:0] = active;
      status_w[31] = attn;
      cause_w = '0;
      cause_w[CODE_W-1:0] = cause;
   end

   always_comb begin
      unique case (rkind)
         ACC_ACT_LO: reg_rd_data = rd_lo;
         ACC_ACT_HI: reg_rd_data = rd_hi;
         ACC_STATUS: reg_rd_data = status_w;
         ACC_CAUSE:  reg_rd_data = cause_w;
         ACC_MISUSE: reg_rd_data = {31'd0, misuse};
         default:    reg_rd_data = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_valid  <= 1'b0;
         issue_slot   <= '0;
         issue_addr   <= '0;
         evt_complete <= 1'b0;
         evt_error    <= 1'b0;
      end else begin
         issue_valid  <= act_ok;
         if (act_ok) begin
            issue_slot <= wslot;
            issue_addr <= {reg_wr_data, wr_lo};
         end
         evt_complete <= done_hit;
         evt_error    <= fail_valid;
      end
   end

   // R2: a staged low word never produces an issue
   a_r2_lo_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
      lo_we |=> !issue_valid);

   // R3: every issue pulse follows an upper-word write
   a_r3_issue_from_hi: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> $past(hi_we));

   // R5: completion events only follow a completion strobe
   a_r5_evt_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      evt_complete |-> $past(done_valid));

   // R6: an error event follows a failure strobe
   a_r6_evt_error: assert property (@(posedge clk) disable iff (!rst_n)
      fail_valid |=> evt_error);

   // R8: initialize leaves every slot idle and attention clear
   a_r8_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      init_clr |=> (active == '0) && !attn && !misuse);

endmodule

// File: tb/csat_tracker_test.sv
`timescale 1ns/1ps
module csat_tracker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic [11:0] reg_rd_addr = '0;
   logic [31:0] reg_rd_data;
   logic        issue_valid;
   logic [4:0]  issue_slot;
   logic [63:0] issue_addr;
   logic        done_valid = 1'b0;
   logic [4:0]  done_slot = '0;
   logic        fail_valid = 1'b0;
   logic [7:0]  fail_code = '0;
   logic        evt_complete, evt_error;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   csat_tracker uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .issue_valid(issue_valid), .issue_slot(issue_slot), .issue_addr(issue_addr),
      .done_valid(done_valid), .done_slot(done_slot),
      .fail_valid(fail_valid), .fail_code(fail_code),
      .evt_complete(evt_complete), .evt_error(evt_error));

   typedef struct packed {
      logic        rd;
      logic [11:0] addr;
      logic [31:0] data;
   } vec_t;

   localparam int NV = 27;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 12'h000, 32'h1000_0040},  // R2 stage slot 0 low
      '{1'b1, 12'h100, 32'h0000_0000},  // R2 still idle
      '{1'b1, 12'h000, 32'h1000_0040},  // R4 low readback
      '{1'b0, 12'h004, 32'h0000_0001},  // R3 arm slot 0
      '{1'b1, 12'h100, 32'h0000_0001},  // R3
      '{1'b1, 12'h004, 32'h0000_0001},  // R4 upper readback
      '{1'b0, 12'h0F0, 32'hAAAA_0000},  // R2 slot 30 low
      '{1'b0, 12'h0F4, 32'h0000_0005},  // R3 arm slot 30
      '{1'b1, 12'h100, 32'h4000_0001},  // R3 top slot
      '{1'b1, 12'h0F0, 32'hAAAA_0000},  // R4
      '{1'b0, 12'h0F8, 32'h0000_0077},  // R10 past last slot
      '{1'b1, 12'h100, 32'h4000_0001},  // R10
      '{1'b1, 12'h0F8, 32'h0000_0000},  // R10 unmapped read
      '{1'b0, 12'h00E, 32'h0000_0001},  // R10 misaligned slot 1 upper
      '{1'b1, 12'h100, 32'h4000_0001},  // R10
      '{1'b1, 12'h108, 32'h0000_0000},  // R9 no misuse yet
      '{1'b0, 12'h004, 32'h0000_0099},  // R9 re-arm busy slot 0
      '{1'b1, 12'h004, 32'h0000_0001},  // R9 descriptor kept
      '{1'b1, 12'h108, 32'h0000_0001},  // R9 misuse flag
      '{1'b0, 12'h000, 32'h0000_0123},  // R9 low write to busy slot
      '{1'b1, 12'h000, 32'h1000_0040},  // R9 low kept
      '{1'b0, 12'h10C, 32'h0000_0000},  // R8 bit 0 clear
      '{1'b1, 12'h100, 32'h4000_0001},  // R8 nothing cleared
      '{1'b0, 12'h10C, 32'h0000_0001},  // R8 initialize
      '{1'b1, 12'h100, 32'h0000_0000},  // R8
      '{1'b1, 12'h108, 32'h0000_0000},  // R8
      '{1'b1, 12'h104, 32'h0000_0000}   // R8
   };

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd_check(string tag, logic [11:0] a, logic [31:0] exp);
      reg_rd_addr = a;
      #1;
      check(tag, 64'(reg_rd_data), 64'(exp));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_check("R1 status", 12'h100, 32'h0);
      rd_check("R1 cause", 12'h104, 32'h0);
      rd_check("R1 misuse", 12'h108, 32'h0);
      check("R1 outputs", {61'd0, issue_valid, evt_complete, evt_error}, 64'd0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].rd) rd_check($sformatf("vector %0d", i), VECS[i].addr, VECS[i].data);
         else            wr(VECS[i].addr, VECS[i].data);
      end

      // R2 and R3: issue pulse content and length
      wr(12'h028, 32'hDEAD_BEEF);
      check("R2 no issue on low", 64'(issue_valid), 64'd0);
      wr(12'h02C, 32'h1234_5678);
      check("R3 issue valid", 64'(issue_valid), 64'd1);
      check("R3 issue slot", 64'(issue_slot), 64'd5);
      check("R3 issue addr", issue_addr, 64'h1234_5678_DEAD_BEEF);
      @(negedge clk);
      check("R3 one-cycle pulse", 64'(issue_valid), 64'd0);

      // R5 completion of busy then idle slot
      done_valid = 1'b1; done_slot = 5'd5;
      @(negedge clk);
      done_valid = 1'b0;
      check("R5 evt_complete", 64'(evt_complete), 64'd1);
      rd_check("R5 slot retired", 12'h100, 32'h0);
      @(negedge clk);
      check("R5 pulse ends", 64'(evt_complete), 64'd0);
      done_valid = 1'b1; done_slot = 5'd5;
      @(negedge clk);
      done_valid = 1'b0;
      check("R5 idle completion ignored", 64'(evt_complete), 64'd0);

      // R6 failure on slot 2
      wr(12'h010, 32'h0000_0040);
      wr(12'h014, 32'h0000_0000);
      @(negedge clk);
      fail_valid = 1'b1; fail_code = 8'd7;
      @(negedge clk);
      fail_valid = 1'b0;
      check("R6 evt_error", 64'(evt_error), 64'd1);
      rd_check("R6 attention and slot kept", 12'h100, 32'h8000_0004);
      rd_check("R6 cause", 12'h104, 32'd7);

      // R7 second failure keeps first cause
      fail_valid = 1'b1; fail_code = 8'd8;
      @(negedge clk);
      fail_valid = 1'b0;
      rd_check("R7 cause kept", 12'h104, 32'd7);
      rd_check("R7 attention kept", 12'h100, 32'h8000_0004);

      // R8 initialize with attention set
      wr(12'h10C, 32'h0000_0001);
      rd_check("R8 status cleared", 12'h100, 32'h0);
      rd_check("R8 cause cleared", 12'h104, 32'h0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule